// File: doc/BRIEF.md
# Binary32 Compare Unit with Sticky Invalid Flag

This block compares two IEEE-754 single-precision operands and returns a one-bit answer in the least significant bit of a 32-bit result word. A 3-bit select chooses one of seven relations: unordered, less-than, equal, less-or-equal, greater-than, not-equal and greater-or-equal. Each request is a single-cycle pulse on `op_valid`. The result is registered and appears on the next clock edge, together with a `res_valid` strobe.

Beside the result, the block keeps a 4-bit sticky status register that holds invalid-operation, divide-by-zero, overflow and underflow bits. A compare can only set the invalid bit. The whole register can be overwritten through a write port, which is how the other bits are loaded or cleared. An exception request is raised when a compare produces an invalid operation while both the configuration trap mask and the machine exception enable are high. At the same time a cause register is loaded with the floating-point cause code.

NaN handling differs by relation. The ordered relations (less, less-or-equal, greater, greater-or-equal) flag every NaN operand as invalid. The unordered, equal and not-equal relations flag only signalling NaNs. The less-than select tests whether B is below A, which is the reverse of the operand order used by the other relations.

Top module: `fcmp_unit`

## Requirements
- R1: One cycle after a clock edge that samples `op_valid` high, `res_valid` is 1 and `res_word` holds the compare bit in bit 0 with bits 31:1 at zero. Select code 7 is reserved: it returns 0 and raises no flag.
- R2: Select 0 (unordered) returns 1 when either operand is a NaN of any kind, and returns 0 otherwise.
- R3: Select 1 (less-than) returns 1 exactly when operand B is ordered below operand A.
- R4: Select 4 (greater-than) returns 1 when A is ordered below B. Select 6 (greater-or-equal) returns the inverse of that test, so it returns 1 whenever an operand is a NaN.
- R5: Select 3 (less-or-equal) returns 1 when A is below or equal to B, and returns 0 if either operand is a NaN.
- R6: Select 2 (equal) returns 1 for equal non-NaN operands, with +0 equal to −0. Select 5 (not-equal) is always its inverse, so it returns 1 for NaN operands.
- R7: Non-NaN operands are ordered by sign and magnitude: every negative value lies below every positive value, a larger magnitude lies lower among negatives, and infinities sit at the two ends.
- R8: A NaN has exponent field 0xFF and a non-zero fraction, and it is signalling when fraction bit 22 is 0. Selects 1, 3, 4 and 6 raise invalid for any NaN operand. Selects 0, 2 and 5 raise invalid only for a signalling NaN.
- R9: Status bits are [0] invalid, [1] divide-by-zero, [2] overflow and [3] underflow. A raised invalid is ORed into bit 0. Compares never change bits 3:1. A write loads all four bits from `sts_wr_data` on the next edge.
- R10: `exc_req` pulses in the result cycle exactly when that compare raised invalid while `trap_mask` and `exc_enable` were both 1. In that case `exc_cause` is loaded with the code 6 and holds it until reset.
- R11: During and after reset, `res_valid`, `res_word`, the status flags, `exc_req` and `exc_cause` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Compare request strobe |
| op_kind | input | 3 | Relation select (0 unordered … 6 greater-or-equal, 7 reserved) |
| opnd_a | input | 32 | Operand A, binary32 |
| opnd_b | input | 32 | Operand B, binary32 |
| trap_mask | input | 1 | Configuration bit permitting floating-point traps |
| exc_enable | input | 1 | Machine-level exception enable |
| sts_wr_en | input | 1 | Overwrite the status register |
| sts_wr_data | input | 4 | Value loaded into the status register |
| res_valid | output | 1 | Result strobe |
| res_word | output | 32 | Result word, compare bit in bit 0 |
| sts_flags | output | 4 | Sticky status flags |
| exc_req | output | 1 | Exception request pulse |
| exc_cause | output | 5 | Exception cause register |

## Verification
The assertions assume that `op_kind` holds a defined value whenever `op_valid` is high. They also assume that a status write and a compare in the same cycle resolve as the write value ORed with the new invalid bit. The stimulus keeps each request to a single-cycle pulse with stable operands and issues status writes only while no compare is in flight, so each expected flag state follows one operation. Operand pairs cover zeros of both signs, subnormals, infinities and both NaN kinds under every select. The trap controls are stepped through all their combinations.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int WORD_W   = 32;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int MAG_W    = WORD_W - 1;
    localparam int FLAG_W   = 4;
    localparam int CAUSE_W  = 5;
    localparam int KIND_W   = 3;

    localparam int FLG_INV  = 0;
    localparam int FLG_DZ   = 1;
    localparam int FLG_OVF  = 2;
    localparam int FLG_UNF  = 3;

    typedef enum logic [KIND_W-1:0] {
        K_UNORD = 3'd0,
        K_LT    = 3'd1,
        K_EQ    = 3'd2,
        K_LE    = 3'd3,
        K_GT    = 3'd4,
        K_NE    = 3'd5,
        K_GE    = 3'd6,
        K_RSV   = 3'd7
    } cmp_kind_e;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             is_nan;
        logic             is_snan;
        logic             is_zero;
    } opnd_class_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
(
    input  logic [WORD_W-1:0] bits,
    output opnd_class_t       cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_all1;
    logic              frac_nz;

    always_comb begin
        exp_f    = bits[WORD_W-2 -: EXP_W];
        frac_f   = bits[FRAC_W-1:0];
        exp_all1 = &exp_f;
        frac_nz  = |frac_f;
        cls.sign    = bits[WORD_W-1];
        cls.mag     = bits[MAG_W-1:0];
        cls.is_nan  = exp_all1 && frac_nz;
        cls.is_snan = exp_all1 && frac_nz && !frac_f[FRAC_W-1];
        cls.is_zero = (bits[MAG_W-1:0] == '0);
    end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
(
    input  opnd_class_t cls_a,
    input  opnd_class_t cls_b,
    output logic        a_lt_b,
    output logic        b_lt_a,
    output logic        a_eq_b,
    output logic        any_nan,
    output logic        any_snan
);
    logic ordered;
    logic both_zero;
    logic mag_a_lo;
    logic mag_b_lo;

    always_comb begin
        any_nan   = cls_a.is_nan  || cls_b.is_nan;
        any_snan  = cls_a.is_snan || cls_b.is_snan;
        ordered   = !any_nan;
        both_zero = cls_a.is_zero && cls_b.is_zero;
        mag_a_lo  = cls_a.mag < cls_b.mag;
        mag_b_lo  = cls_b.mag < cls_a.mag;
        a_lt_b = 1'b0;
        b_lt_a = 1'b0;
        if (ordered && !both_zero) begin
            if (cls_a.sign != cls_b.sign) begin
                a_lt_b = cls_a.sign;
                b_lt_a = cls_b.sign;
            end else if (!cls_a.sign) begin
                a_lt_b = mag_a_lo;
                b_lt_a = mag_b_lo;
            end else begin
                a_lt_b = mag_b_lo;
                b_lt_a = mag_a_lo;
            end
        end
        a_eq_b = ordered && (both_zero ||
                 ((cls_a.sign == cls_b.sign) && (cls_a.mag == cls_b.mag)));
    end
endmodule

// File: rtl/fcmp_status.sv
module fcmp_status
    import fcmp_pkg::*;
#(
    parameter logic [CAUSE_W-1:0] CAUSE_FPU = 5'd6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               raise_inv,
    input  logic               trap_mask,
    input  logic               exc_enable,
    input  logic               wr_en,
    input  logic [FLAG_W-1:0]  wr_data,
    output logic [FLAG_W-1:0]  flags,
    output logic               exc_req,
    output logic [CAUSE_W-1:0] cause
);
    typedef struct packed {
        logic [FLAG_W-1:0]  flags;
        logic               exc;
        logic [CAUSE_W-1:0] cause;
    } sts_state_t;

    sts_state_t st_d, st_q;
    logic [FLAG_W-1:0] base;
    logic [FLAG_W-1:0] inv_vec;

    always_comb begin
        base    = wr_en ? wr_data : st_q.flags;
        inv_vec = '0;
        inv_vec[FLG_INV] = raise_inv;
        st_d       = st_q;
        st_d.flags = base | inv_vec;
        st_d.exc   = raise_inv && trap_mask && exc_enable;
        if (st_d.exc) begin
            st_d.cause = CAUSE_FPU;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags   = st_q.flags;
    assign exc_req = st_q.exc;
    assign cause   = st_q.cause;

    p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((flags & $past(flags)) == $past(flags)));
    p_upper_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (flags[FLAG_W-1:1] == $past(flags[FLAG_W-1:1])));
    p_exc_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_mask && exc_enable) |=> !exc_req);
    p_exc_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (flags[FLG_INV] && cause == CAUSE_FPU));
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [KIND_W-1:0]   op_kind,
    input  logic [WORD_W-1:0]   opnd_a,
    input  logic [WORD_W-1:0]   opnd_b,
    input  logic                trap_mask,
    input  logic                exc_enable,
    input  logic                sts_wr_en,
    input  logic [FLAG_W-1:0]   sts_wr_data,
    output logic                res_valid,
    output logic [WORD_W-1:0]   res_word,
    output logic [FLAG_W-1:0]   sts_flags,
    output logic                exc_req,
    output logic [CAUSE_W-1:0]  exc_cause
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
    } res_state_t;

    opnd_class_t cls [2];
    logic [WORD_W-1:0] opnd [2];
    logic a_lt_b, b_lt_a, a_eq_b, any_nan, any_snan;
    logic cmp_bit, cmp_inv;
    res_state_t rs_d, rs_q;

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fcmp_classify u_cls (
            .bits (opnd[gi]),
            .cls  (cls[gi])
        );
    end

    fcmp_relate u_rel (
        .cls_a    (cls[0]),
        .cls_b    (cls[1]),
        .a_lt_b   (a_lt_b),
        .b_lt_a   (b_lt_a),
        .a_eq_b   (a_eq_b),
        .any_nan  (any_nan),
        .any_snan (any_snan)
    );

    always_comb begin
        cmp_bit = 1'b0;
        cmp_inv = 1'b0;
        case (cmp_kind_e'(op_kind))
            K_UNORD: begin cmp_bit = any_nan;            cmp_inv = any_snan; end
            K_LT:    begin cmp_bit = b_lt_a;             cmp_inv = any_nan;  end
            K_EQ:    begin cmp_bit = a_eq_b;             cmp_inv = any_snan; end
            K_LE:    begin cmp_bit = a_lt_b || a_eq_b;   cmp_inv = any_nan;  end
            K_GT:    begin cmp_bit = a_lt_b;             cmp_inv = any_nan;  end
            K_NE:    begin cmp_bit = !a_eq_b;            cmp_inv = any_snan; end
            K_GE:    begin cmp_bit = !a_lt_b;            cmp_inv = any_nan;  end
            default: begin cmp_bit = 1'b0;               cmp_inv = 1'b0;     end
        endcase
        rs_d.vld  = op_valid;
        rs_d.word = rs_q.word;
        if (op_valid) begin
            rs_d.word = {{(WORD_W-1){1'b0}}, cmp_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    fcmp_status u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_inv  (op_valid && cmp_inv),
        .trap_mask  (trap_mask),
        .exc_enable (exc_enable),
        .wr_en      (sts_wr_en),
        .wr_data    (sts_wr_data),
        .flags      (sts_flags),
        .exc_req    (exc_req),
        .cause      (exc_cause)
    );

    assign res_valid = rs_q.vld;
    assign res_word  = rs_q.word;

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    p_unord_nan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == K_UNORD && (cls[0].is_nan || cls[1].is_nan))
        |=> res_word[0]);
    p_ordered_nan_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind != K_UNORD && op_kind != K_EQ && op_kind != K_NE
         && op_kind != K_RSV && (cls[0].is_nan || cls[1].is_nan))
        |=> sts_flags[FLG_INV]);
    p_nan_le_false_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == K_LE && (cls[0].is_nan || cls[1].is_nan))
        |=> !res_word[0]);
    p_exc_only_on_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> res_valid);
endmodule

// File: tb/sim_fcmp_unit.sv
module sim_fcmp_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_kind;
    logic [31:0] opnd_a, opnd_b;
    logic        trap_mask, exc_enable;
    logic        sts_wr_en;
    logic [3:0]  sts_wr_data;
    logic        res_valid;
    logic [31:0] res_word;
    logic [3:0]  sts_flags;
    logic        exc_req;
    logic [4:0]  exc_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0]  kind;
        logic [31:0] word;
        logic [3:0]  flags;
        logic        exc;
        logic [4:0]  cause;
    } exp_t;
    exp_t sb[$];

    logic [3:0] m_flags;
    logic [4:0] m_cause;

    always #4 clk = ~clk;

    fcmp_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .trap_mask(trap_mask),
        .exc_enable(exc_enable), .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
        .res_valid(res_valid), .res_word(res_word), .sts_flags(sts_flags),
        .exc_req(exc_req), .exc_cause(exc_cause)
    );

    function automatic bit m_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction
    function automatic bit m_snan(logic [31:0] x);
        return m_nan(x) && !x[22];
    endfunction
    // R7: sign-magnitude ordering of non-NaN values
    function automatic bit m_lt(logic [31:0] x, logic [31:0] y);
        if (m_nan(x) || m_nan(y)) return 1'b0;
        if (x[30:0] == 0 && y[30:0] == 0) return 1'b0;
        if (x[31] != y[31]) return x[31];
        if (!x[31]) return x[30:0] < y[30:0];
        return x[30:0] > y[30:0];
    endfunction
    function automatic bit m_eq(logic [31:0] x, logic [31:0] y);
        if (m_nan(x) || m_nan(y)) return 1'b0;
        if (x[30:0] == 0 && y[30:0] == 0) return 1'b1;
        return x == y;
    endfunction
    function automatic string tag_of(logic [2:0] k);
        case (k)
            3'd0: return "R2";
            3'd1: return "R3 R7";
            3'd2: return "R6";
            3'd3: return "R5 R7";
            3'd4: return "R4 R7";
            3'd5: return "R6";
            3'd6: return "R4";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: computes expectations and pushes them
    task automatic do_cmp(logic [2:0] k, logic [31:0] a, logic [31:0] b);
        exp_t e;
        bit r, inv;
        case (k)
            3'd0: begin r = m_nan(a) || m_nan(b); inv = m_snan(a) || m_snan(b); end
            3'd1: begin r = m_lt(b, a); inv = m_nan(a) || m_nan(b); end
            3'd2: begin r = m_eq(a, b); inv = m_snan(a) || m_snan(b); end
            3'd3: begin r = m_lt(a, b) || m_eq(a, b); inv = m_nan(a) || m_nan(b); end
            3'd4: begin r = m_lt(a, b); inv = m_nan(a) || m_nan(b); end
            3'd5: begin r = !m_eq(a, b); inv = m_snan(a) || m_snan(b); end
            3'd6: begin r = !m_lt(a, b); inv = m_nan(a) || m_nan(b); end
            default: begin r = 1'b0; inv = 1'b0; end
        endcase
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; opnd_a = a; opnd_b = b;
        m_flags[0] = m_flags[0] | inv;
        e.exc = inv && trap_mask && exc_enable;
        if (e.exc) m_cause = 5'd6;
        e.kind = k; e.word = {31'd0, r}; e.flags = m_flags; e.cause = m_cause;
        sb.push_back(e);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr_flags(logic [3:0] v);
        drain();
        sts_wr_en = 1'b1; sts_wr_data = v;
        @(negedge clk);
        sts_wr_en = 1'b0;
        m_flags = v;
        chk("R9 write", {28'd0, sts_flags}, {28'd0, v});
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (res_valid) begin
                if (sb.size() == 0) begin
                    chk("R1 unexpected result", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({tag_of(e.kind), " result"}, res_word, e.word);
                    chk("R8 R9 flags", {28'd0, sts_flags}, {28'd0, e.flags});
                    chk("R10 exc_req", {31'd0, exc_req}, {31'd0, e.exc});
                    chk("R10 cause", {27'd0, exc_cause}, {27'd0, e.cause});
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam int NV = 12;
    logic [31:0] vals [NV];

    initial begin
        vals[0] = 32'h3F800000;  vals[1] = 32'h40000000;
        vals[2] = 32'hBF800000;  vals[3] = 32'hC0000000;
        vals[4] = 32'h00000000;  vals[5] = 32'h80000000;
        vals[6] = 32'h7F800000;  vals[7] = 32'hFF800000;
        vals[8] = 32'h7FC00000;  vals[9] = 32'h7F800001;
        vals[10] = 32'h00000001; vals[11] = 32'hFFA00000;
        rst_n = 1'b0; op_valid = 1'b0; op_kind = 3'd0; opnd_a = 0; opnd_b = 0;
        trap_mask = 1'b0; exc_enable = 1'b0; sts_wr_en = 1'b0; sts_wr_data = 0;
        m_flags = 0; m_cause = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 res_valid", {31'd0, res_valid}, 32'd0);
        chk("R11 res_word", res_word, 32'd0);
        chk("R11 flags", {28'd0, sts_flags}, 32'd0);
        chk("R11 exc", {26'd0, exc_req, exc_cause}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", {27'd0, res_valid, sts_flags}, 32'd0);

        // all selects over all operand pairs, traps off
        for (int k = 0; k < 8; k++)
            for (int i = 0; i < NV; i++)
                for (int j = 0; j < NV; j++)
                    do_cmp(3'(k), vals[i], vals[j]);
        drain();

        // R9: load upper flags, ensure compares leave them
        wr_flags(4'b1010);
        do_cmp(3'd1, vals[8], vals[0]);
        do_cmp(3'd2, vals[0], vals[0]);
        wr_flags(4'b0000);
        // R8: quiet NaN under quiet compare raises nothing
        do_cmp(3'd2, vals[8], vals[0]);
        do_cmp(3'd5, vals[0], vals[8]);
        drain();

        // R10: trap controls in every combination
        for (int t = 0; t < 4; t++) begin
            wr_flags(4'b0000);
            trap_mask = t[0]; exc_enable = t[1];
            do_cmp(3'd0, vals[9], vals[0]);
            do_cmp(3'd4, vals[8], vals[1]);
            do_cmp(3'd5, vals[8], vals[1]);
            do_cmp(3'd7, vals[9], vals[9]);
            do_cmp(3'd3, vals[2], vals[3]);
        end
        drain();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_cause = 0; m_flags = 0;
        chk("R11 cause cleared", {27'd0, exc_cause}, 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule